// File: doc/BRIEF.md
# Compressed Tsetlin Inference Engine

This block is a streaming inference core for a Tsetlin Machine classifier. It uses no multiplier. It accepts one input stream with valid, ready and last signals. The first word of every payload is a header, and its top bit says what follows. A model payload is a sparse list of 16-bit instructions. Each instruction points at one included literal and marks where clauses and classes end. The block writes the list into an internal instruction memory. A feature payload fills a Boolean feature buffer, then the stored list is run to produce a predicted class.

During a run, each feature supplies two literals: the feature value and its complement. One instruction is handled per clock. A clause output is the AND of the literals it refers to. Clauses take turns adding and subtracting one from the sum of their class. When a class is closed, its sum is compared with the best sum so far. Classes, clauses and features are all sized at runtime from the headers and the stored list, so a new model or input width needs only a new stream.

Top module: `tm_stream_core`

## Requirements
- R1: A header has bit 15 = 0 for a model and 1 for features. A model header gives the class count minus one in bits [4:0]. A feature header gives the feature count in bits [8:0]. `s_tready` is high while the core is not executing.
- R2: The words after a model header are stored in order, up to the memory depth, until the word with `s_tlast`. A new model fully replaces the previous one, and the model stays in place for any number of feature payloads.
- R3: Feature word w, bit j, carries feature 16*w+j. A feature at or above the header's feature count makes both of its literals false.
- R4: An instruction holds the literal index in bits [11:0], a clause-end flag in bit 12 and a class-end flag in bit 13. A class end also closes the clause. Literal 2k is feature k and literal 2k+1 is its complement. Index 0xFFF is a null entry that includes nothing.
- R5: A clause outputs the AND of its included literals. A clause with no included literal outputs 0.
- R6: Within a class, clause 0, 2, 4, ... adds 1 to the signed 16-bit class sum when it outputs 1. Clause 1, 3, ... subtracts 1. Every class starts at 0.
- R7: A run ends when the last class given by the header closes, or when the stored list runs out. An unfinished class is then dropped. `result_valid` then pulses for one cycle. `result_class` gives the index of the highest closed sum, with ties going to the lower index, and `result_score` gives that sum. If no class closed, both are 0. The outputs hold between pulses.
- R8: `s_tready` stays low from the accepted last feature word until `result_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 16 | Stream data word |
| s_tvalid | input | 1 | Stream word valid |
| s_tlast | input | 1 | Last word of a payload |
| s_tready | output | 1 | Core accepts a word |
| result_valid | output | 1 | One-cycle pulse at the end of a run |
| result_class | output | 6 | Winning class index |
| result_score | output | 16 | Winning class sum (signed) |

## Verification
The bench goes after the corner cases most likely to be wrong:
- **Empty clause.** A design that treats an empty clause as true scores it +1.
- **Ties.** A design that replaces the best class on an equal sum reports the higher index.
- **Inverted literals.** Mixing up a literal and its complement flips clause outputs.
- **Features past the count.** If these are not masked, complement literals read as 1.
- **Early stop on class count.** A header class count smaller than the list must stop the run early. Otherwise a later class that should be ignored can win.
- **List runs out mid-class.** A list that ends inside a class must drop that class.

Random models of varied shape, reloaded between feature vectors, also check the alternating clause polarity and the model staying in place across runs.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int WORD_W   = 16;
    localparam int LIT_W    = 12;
    localparam int CLS_W    = 6;
    localparam int SUM_W    = 16;
    localparam int FCNT_W   = 9;
    localparam int FEAT_PER_WORD = 16;
    localparam logic [LIT_W-1:0] NULL_LIT = '1;

    typedef struct packed {
        logic [1:0]       spare;
        logic             class_end;
        logic             clause_end;
        logic [LIT_W-1:0] lit;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD_M,
        ST_LOAD_F,
        ST_EXEC
    } state_t;

    function automatic logic hdr_is_feat(input logic [WORD_W-1:0] w);
        return w[15];
    endfunction

    function automatic logic [CLS_W-1:0] hdr_classes(input logic [WORD_W-1:0] w);
        return {1'b0, w[4:0]} + CLS_W'(1);
    endfunction

    function automatic logic [FCNT_W-1:0] hdr_features(input logic [WORD_W-1:0] w);
        return w[FCNT_W-1:0];
    endfunction
endpackage

// File: rtl/tm_imem.sv
module tm_imem #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [tm_pkg::WORD_W-1:0] wdata,
    input  logic [AW-1:0]            raddr,
    output logic [tm_pkg::WORD_W-1:0] rdata
);
    logic [tm_pkg::WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tm_lit_buf.sv
module tm_lit_buf
    import tm_pkg::*;
#(
    parameter int MAX_FEAT = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [FCNT_W-1:0]   cnt_in,
    input  logic                wr_en,
    input  logic [$clog2(MAX_FEAT/FEAT_PER_WORD)-1:0] wr_word,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [LIT_W-1:0]    lit,
    output logic                lit_val
);
    localparam int NWORDS = MAX_FEAT / FEAT_PER_WORD;
    localparam int NLITS  = 2 * MAX_FEAT;

    logic [NWORDS-1:0][FEAT_PER_WORD-1:0] feat_q;
    logic [FCNT_W-1:0] cnt_q;
    logic [NLITS-1:0]  lits;

    always_ff @(posedge clk) begin
        if (rst) begin
            feat_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            feat_q <= '0;
            cnt_q  <= cnt_in;
        end else if (wr_en) begin
            feat_q[wr_word] <= wr_data;
        end
    end

    // every feature yields itself and its complement, both gated by the count
    for (genvar f = 0; f < MAX_FEAT; f++) begin : g_lit
        logic present;
        assign present       = (32'(cnt_q) > f);
        assign lits[2*f]     = present &  feat_q[f / FEAT_PER_WORD][f % FEAT_PER_WORD];
        assign lits[2*f + 1] = present & ~feat_q[f / FEAT_PER_WORD][f % FEAT_PER_WORD];
    end

    always_comb begin
        lit_val = 1'b0;
        if (32'(lit) < NLITS) lit_val = lits[lit[$clog2(NLITS)-1:0]];
    end
endmodule

// File: rtl/tm_class_acc.sv
module tm_class_acc
    import tm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    step,
    input  instr_t                  ins,
    input  logic                    lit_val,
    output logic [CLS_W-1:0]        cls_idx,
    output logic signed [SUM_W-1:0] cls_sum,
    output logic [CLS_W-1:0]        best_idx_nxt,
    output logic signed [SUM_W-1:0] best_sum_nxt
);
    logic                    and_q, has_q, odd_q, any_q;
    logic signed [SUM_W-1:0] sum_q, best_q;
    logic [CLS_W-1:0]        idx_q, bidx_q;

    logic                    is_null, and_n, has_n, clause_out, closes;
    logic signed [SUM_W-1:0] sum_n;
    logic                    better;

    always_comb begin
        is_null    = (ins.lit == NULL_LIT);
        and_n      = and_q & (is_null | lit_val);
        has_n      = has_q | ~is_null;
        clause_out = and_n & has_n;
        closes     = ins.clause_end | ins.class_end;
        sum_n      = sum_q;
        if (closes && clause_out) sum_n = odd_q ? sum_q - SUM_W'(1) : sum_q + SUM_W'(1);
        better       = step && ins.class_end && (!any_q || sum_n > best_q);
        best_idx_nxt = better ? idx_q : bidx_q;
        best_sum_nxt = better ? sum_n : best_q;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            and_q  <= 1'b1;
            has_q  <= 1'b0;
            odd_q  <= 1'b0;
            any_q  <= 1'b0;
            sum_q  <= '0;
            best_q <= '0;
            idx_q  <= '0;
            bidx_q <= '0;
        end else if (step) begin
            if (ins.class_end) begin
                and_q  <= 1'b1;
                has_q  <= 1'b0;
                odd_q  <= 1'b0;
                sum_q  <= '0;
                any_q  <= 1'b1;
                idx_q  <= idx_q + CLS_W'(1);
                best_q <= best_sum_nxt;
                bidx_q <= best_idx_nxt;
            end else if (ins.clause_end) begin
                and_q <= 1'b1;
                has_q <= 1'b0;
                odd_q <= ~odd_q;
                sum_q <= sum_n;
            end else begin
                and_q <= and_n;
                has_q <= has_n;
            end
        end
    end

    assign cls_idx = idx_q;
    assign cls_sum = sum_q;
endmodule

// File: rtl/tm_stream_core.sv
module tm_stream_core
    import tm_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int MAX_FEAT   = 256
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [WORD_W-1:0]       s_tdata,
    input  logic                    s_tvalid,
    input  logic                    s_tlast,
    output logic                    s_tready,
    output logic                    result_valid,
    output logic [CLS_W-1:0]        result_class,
    output logic signed [SUM_W-1:0] result_score
);
    localparam int AW     = $clog2(IMEM_DEPTH);
    localparam int LEN_W  = AW + 1;
    localparam int NWORDS = MAX_FEAT / FEAT_PER_WORD;
    localparam int WIDX_W = $clog2(NWORDS);

    state_t            state_q;
    logic [LEN_W-1:0]  wptr_q, mlen_q, pc_q;
    logic [CLS_W-1:0]  ncls_q;

    logic              hs, imem_we, lb_clr, lb_we, start, step, fin;
    logic [WORD_W-1:0] imem_rd;
    instr_t            ins;
    logic              lit_val;
    logic [CLS_W-1:0]  cls_idx, best_idx_nxt;
    logic signed [SUM_W-1:0] acc_sum, best_sum_nxt;

    assign s_tready = (state_q != ST_EXEC);
    assign hs       = s_tvalid & s_tready;
    assign ins      = instr_t'(imem_rd);

    always_comb begin
        imem_we = hs && state_q == ST_LOAD_M && 32'(wptr_q) < IMEM_DEPTH;
        lb_clr  = hs && state_q == ST_IDLE && hdr_is_feat(s_tdata);
        lb_we   = hs && state_q == ST_LOAD_F && 32'(wptr_q) < NWORDS;
        start   = hs && s_tlast && ((state_q == ST_LOAD_F) ||
                                    (state_q == ST_IDLE && hdr_is_feat(s_tdata)));
        step    = (state_q == ST_EXEC) && (pc_q < mlen_q);
        fin     = (state_q == ST_EXEC) &&
                  (!step || (ins.class_end && cls_idx == ncls_q - CLS_W'(1)));
    end

    tm_imem #(.DEPTH(IMEM_DEPTH), .AW(AW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (wptr_q[AW-1:0]),
        .wdata (s_tdata),
        .raddr (pc_q[AW-1:0]),
        .rdata (imem_rd)
    );

    tm_lit_buf #(.MAX_FEAT(MAX_FEAT)) u_lits (
        .clk     (clk),
        .rst     (rst),
        .clr     (lb_clr),
        .cnt_in  (hdr_features(s_tdata)),
        .wr_en   (lb_we),
        .wr_word (wptr_q[WIDX_W-1:0]),
        .wr_data (s_tdata),
        .lit     (ins.lit),
        .lit_val (lit_val)
    );

    tm_class_acc u_acc (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .step         (step),
        .ins          (ins),
        .lit_val      (lit_val),
        .cls_idx      (cls_idx),
        .cls_sum      (acc_sum),
        .best_idx_nxt (best_idx_nxt),
        .best_sum_nxt (best_sum_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            wptr_q       <= '0;
            mlen_q       <= '0;
            pc_q         <= '0;
            ncls_q       <= CLS_W'(1);
            result_valid <= 1'b0;
            result_class <= '0;
            result_score <= '0;
        end else begin
            result_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (hs) begin
                    wptr_q <= '0;
                    if (hdr_is_feat(s_tdata)) begin
                        pc_q    <= '0;
                        state_q <= s_tlast ? ST_EXEC : ST_LOAD_F;
                    end else begin
                        ncls_q  <= hdr_classes(s_tdata);
                        mlen_q  <= '0;
                        state_q <= s_tlast ? ST_IDLE : ST_LOAD_M;
                    end
                end
                ST_LOAD_M: if (hs) begin
                    if (imem_we) begin
                        wptr_q <= wptr_q + LEN_W'(1);
                        mlen_q <= wptr_q + LEN_W'(1);
                    end
                    if (s_tlast) state_q <= ST_IDLE;
                end
                ST_LOAD_F: if (hs) begin
                    if (lb_we) wptr_q <= wptr_q + LEN_W'(1);
                    if (s_tlast) begin
                        pc_q    <= '0;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (step) pc_q <= pc_q + LEN_W'(1);
                    if (fin) begin
                        state_q      <= ST_IDLE;
                        result_valid <= 1'b1;
                        result_class <= best_idx_nxt;
                        result_score <= best_sum_nxt;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tm_stream_core_chk.sv
module tm_stream_core_chk
    import tm_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    s_tready,
    input logic                    result_valid,
    input logic [CLS_W-1:0]        result_class,
    input logic signed [SUM_W-1:0] result_score,
    input logic [CLS_W-1:0]        ncls_q,
    input logic signed [SUM_W-1:0] cls_sum
);
    p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    p_ready_after_result_r8: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> s_tready);

    p_hold_class_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_class) |-> result_valid);

    p_hold_score_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_score) |-> result_valid);

    p_class_range_r7: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (result_class < ncls_q));

    p_sum_step_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cls_sum) |-> (cls_sum == $past(cls_sum) + SUM_W'(1) ||
                               cls_sum == $past(cls_sum) - SUM_W'(1) ||
                               cls_sum == '0));
endmodule

bind tm_stream_core tm_stream_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .s_tready     (s_tready),
    .result_valid (result_valid),
    .result_class (result_class),
    .result_score (result_score),
    .ncls_q       (ncls_q),
    .cls_sum      (acc_sum)
);

// File: tb/tm_stream_core_tb.sv
module tm_stream_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic        result_valid;
    logic [5:0]  result_class;
    logic signed [15:0] result_score;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0]  mw [256];
    int           mlen_b = 0;
    int           ncls_b = 1;
    logic [255:0] fv = '0;
    int           nfeat_b = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tm_stream_core u_dut (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tready(s_tready), .result_valid(result_valid),
        .result_class(result_class), .result_score(result_score)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic logic [15:0] iw(input int lit, input bit ce, input bit ke);
        return {2'b00, ke, ce, lit[11:0]};
    endfunction

    task automatic send(input logic [15:0] d, input logic last);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = d; s_tlast = last;
        while (!s_tready) @(negedge clk);
        @(posedge clk);
        #1;
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    task automatic load_model(input int hdr_cls);
        ncls_b = hdr_cls;
        send({1'b0, 10'd0, 5'(hdr_cls - 1)}, mlen_b == 0);
        for (int i = 0; i < mlen_b; i++) send(mw[i], i == mlen_b - 1);
    endtask

    task automatic ref_run(output int ec, output int es);
        int sum = 0, odd = 0, andv = 1, has = 0, cidx = 0, best = 0, bidx = 0, any = 0;
        for (int i = 0; i < mlen_b; i++) begin
            logic [15:0] w = mw[i];
            int lit = int'(w[11:0]);
            bit nul = (lit == 12'hFFF);
            int f = lit / 2;
            bit v = (!nul && f < nfeat_b && f < 256) ? (fv[f] ^ lit[0]) : 1'b0;
            if (!nul) begin has = 1; if (!v) andv = 0; end
            if (w[12] || w[13]) begin
                if (andv && has) sum += (odd ? -1 : 1);
                odd ^= 1; andv = 1; has = 0;
            end
            if (w[13]) begin
                if (!any || sum > best) begin best = sum; bidx = cidx; end
                any = 1;
                if (cidx == ncls_b - 1) break;
                cidx++; sum = 0; odd = 0;
            end
        end
        ec = bidx; es = best;
    endtask

    // sends features and checks R8 busy window, R7 result and pulse width
    task automatic run_feat(input string tag);
        int nw = (nfeat_b + 15) / 16;
        int ec, es, waitc;
        bit busy_ok = 1;
        ref_run(ec, es);
        send({1'b1, 6'd0, 9'(nfeat_b)}, nw == 0);
        for (int w = 0; w < nw; w++) send(fv[w*16 +: 16], w == nw - 1);
        waitc = 0;
        forever begin
            @(negedge clk);
            if (result_valid) break;
            if (s_tready) busy_ok = 0;
            waitc++;
            if (waitc > 2000) break;
        end
        chk({tag, " R8 busy"}, busy_ok, 1);
        chk({tag, " R7 valid"}, result_valid, 1);
        chk({tag, " R7 class"}, result_class, ec);
        chk({tag, " R6 score"}, result_score, es);
        @(negedge clk);
        chk({tag, " R7 pulse"}, result_valid, 0);
        chk({tag, " R1 ready"}, s_tready, 1);
    endtask

    task automatic gen_model(input int nc, input int nf);
        mlen_b = 0;
        for (int c = 0; c < nc; c++) begin
            int ncl = $urandom_range(1, 4);
            for (int k = 0; k < ncl; k++) begin
                int nl = $urandom_range(0, 3);
                bit ke = (k == ncl - 1);
                if (nl == 0) begin
                    mw[mlen_b] = iw(12'hFFF, 1, ke); mlen_b++;
                end else begin
                    for (int l = 0; l < nl; l++) begin
                        int lit = ($urandom_range(0, 9) == 0) ?
                                  2*nf + $urandom_range(0, 7) : $urandom_range(0, 2*nf - 1);
                        mw[mlen_b] = iw(lit, l == nl - 1, ke && l == nl - 1);
                        mlen_b++;
                    end
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", s_tready, 1);
        chk("R7 reset valid", result_valid, 0);
        chk("R7 reset class", result_class, 0);

        // no model stored: run ends at once with class 0, score 0 (R7)
        nfeat_b = 4; fv = '0; fv[3:0] = 4'b1111;
        run_feat("empty-model");

        // R7 tie goes to lower index
        mw[0] = iw(0, 1, 1); mw[1] = iw(2, 1, 1); mlen_b = 2;
        load_model(2);
        fv = '0; fv[1:0] = 2'b11; nfeat_b = 2;
        run_feat("tie");

        // R5 empty clause outputs 0
        mw[0] = iw(12'hFFF, 1, 1); mw[1] = iw(0, 1, 1); mlen_b = 2;
        load_model(2);
        fv = '0; nfeat_b = 2;
        run_feat("empty-clause");

        // R4 complement literal, R3 feature beyond count reads false both ways
        mw[0] = iw(1, 1, 1); mw[1] = iw(3, 1, 1); mw[2] = iw(21, 1, 1); mlen_b = 3;
        load_model(3);
        fv = '0; fv[3:0] = 4'b0101; fv[10] = 1'b1; nfeat_b = 4;
        run_feat("literals");

        // R6 alternating polarity
        mw[0] = iw(0, 1, 0); mw[1] = iw(0, 1, 0); mw[2] = iw(0, 1, 1);
        mw[3] = iw(3, 1, 0); mw[4] = iw(2, 1, 1); mlen_b = 5;
        load_model(2);
        fv = '0; fv[1:0] = 2'b11; nfeat_b = 2;
        run_feat("polarity");
        // R2 model kept for a second feature vector
        fv[1:0] = 2'b10;
        run_feat("reuse");

        // R7 header class count stops the run before a winning later class
        mw[0] = iw(12'hFFF, 1, 1); mw[1] = iw(12'hFFF, 1, 1);
        mw[2] = iw(0, 1, 1); mlen_b = 3;
        load_model(2);
        fv = '0; fv[0] = 1'b1; nfeat_b = 1;
        run_feat("class-limit");

        // R7 list ends inside an open class, which is dropped
        mw[0] = iw(1, 1, 1); mw[1] = iw(0, 1, 0); mlen_b = 2;
        load_model(3);
        fv = '0; fv[0] = 1'b1; nfeat_b = 1;
        run_feat("open-class");

        // random models and feature vectors, model reloaded now and then (R2)
        for (int t = 0; t < 40; t++) begin
            int nf = $urandom_range(1, 64);
            if (t == 0 || $urandom_range(0, 2) == 0) begin
                int nc = $urandom_range(1, 6);
                gen_model(nc, nf);
                load_model(($urandom_range(0, 3) == 0) ? $urandom_range(1, nc) : nc);
            end
            nfeat_b = $urandom_range(0, 70);
            fv = '0;
            for (int w = 0; w < 16; w++) fv[w*16 +: 16] = 16'($urandom);
            for (int b = 0; b < 256; b++) if (b >= ((nfeat_b + 15) / 16) * 16) fv[b] = 1'b0;
            run_feat("random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule